// File: doc/BRIEF.md
# Debug-aware low-power clock controller

This block chooses which clocks keep running and which peripherals are held still while a debugger is attached to the core. It follows the core's low-power state. Sleep or stop is entered only when the core executes a wait instruction, and a wakeup event brings the block back to run. It also follows the core's halted (breakpoint) status. A single debug control word, written over a simple one-cycle register bus, changes both behaviours.

Gating is modelled as enable outputs: one enable for the core free-running clock, one for the bus clock, and a select that switches both to the internal RC oscillator. With a debug override bit set, a low-power mode keeps the clocks a debugger needs. Separate freeze bits let each timer and the watchdog either stop or keep counting during a breakpoint. A further bit blocks updates of the CAN receive register while the core is halted.

Top module: `dbgclk_ctrl`

## Requirements
- R1: After a synchronous reset the control word reads 0. The block is in run mode with `fclk_en`=1, `hclk_en`=1 and `clk_sel_rc`=0, and every freeze output is 0.
- R2: A write with `wr_en`=1 stores `wr_data` in the cycle after the write, and `rd_data` then returns it. Only these bits are kept: bit 0 (sleep debug), bit 1 (stop debug), bit 2 (watchdog freeze), bit 3 (CAN hold) and bits 8 to 8+NUM_TIMERS-1 (timer freeze, timer i at bit 8+i). Every other bit reads 0.
- R3: Without `wait_exec`=1 the block stays in run mode, whatever `deep_req` is. A cycle with `wait_exec`=1 in run mode enters stop when `deep_req`=1 and sleep when `deep_req`=0, effective the next cycle.
- R4: In sleep mode with bit 0 clear: `fclk_en`=1, `hclk_en`=0, `clk_sel_rc`=0.
- R5: In sleep mode with bit 0 set: `fclk_en`=1, `hclk_en`=1, `clk_sel_rc`=0. The bus clock runs from the system clock.
- R6: In stop mode with bit 1 clear: `fclk_en`=0, `hclk_en`=0, `clk_sel_rc`=0.
- R7: In stop mode with bit 1 set: `fclk_en`=1, `hclk_en`=1, `clk_sel_rc`=1. The RC oscillator drives both clocks.
- R8: `wakeup`=1 in sleep or stop returns the block to run mode in the next cycle, with both enables at 1 and `clk_sel_rc`=0.
- R9: On each clock edge `tim_freeze[i]` takes (`core_halted` AND timer bit i) and `wdog_freeze` takes (`core_halted` AND bit 2). With the bit clear, the output stays 0 through a halt.
- R10: On each clock edge `can_rx_hold` takes (`core_halted` AND bit 3). It stays 1 for as long as the halt lasts.
- R11: In run mode, a cycle with `wait_exec`=1 and `wakeup`=1 together leaves the block in run mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Current control word, unused bits zero |
| core_halted | input | 1 | Core is stopped at a breakpoint |
| wait_exec | input | 1 | Core executes a wait-for-interrupt or wait-for-event instruction |
| deep_req | input | 1 | Selects stop (1) or sleep (0) on a wait instruction |
| wakeup | input | 1 | Wakeup event |
| fclk_en | output | 1 | Core free-running clock enable |
| hclk_en | output | 1 | Bus clock enable |
| clk_sel_rc | output | 1 | 1 selects the internal RC oscillator, 0 the system clock |
| tim_freeze | output | NUM_TIMERS | Per-timer counter freeze |
| wdog_freeze | output | 1 | Watchdog counter freeze |
| can_rx_hold | output | 1 | Blocks updates of the CAN receive register |

## Verification
The embedded properties check on every cycle:
- register write-back and masking;
- that a mode is left only through wakeup and entered only through a wait instruction;
- the clock-enable pattern of both stop variants and of the plain sleep mode;
- that no freeze output rises without a halt in the cycle before.

Only the bench's scenarios can show some behaviours:
- the full sequence of mode entry by `deep_req`;
- the collision of wakeup and wait;
- per-bit independence of the timer freezes under changing halt patterns;
- control writes made while the block is in a low-power mode.

// File: rtl/dbgclk_pkg.sv
package dbgclk_pkg;

    localparam int REG_W         = 32;
    localparam int BIT_SLEEP_DBG = 0;
    localparam int BIT_STOP_DBG  = 1;
    localparam int BIT_WDOG_FRZ  = 2;
    localparam int BIT_CAN_HOLD  = 3;
    localparam int TIM_LSB       = 8;

    typedef enum logic [1:0] {
        PM_RUN   = 2'd0,
        PM_SLEEP = 2'd1,
        PM_STOP  = 2'd2
    } pmode_e;

    typedef struct packed {
        logic fclk_en;
        logic hclk_en;
        logic sel_rc;
    } clkctl_t;

    function automatic logic [REG_W-1:0] ctrl_mask(input int n_tim);
        logic [REG_W-1:0] m;
        m = '0;
        m[BIT_SLEEP_DBG] = 1'b1;
        m[BIT_STOP_DBG]  = 1'b1;
        m[BIT_WDOG_FRZ]  = 1'b1;
        m[BIT_CAN_HOLD]  = 1'b1;
        for (int i = 0; i < n_tim; i++) begin
            m[TIM_LSB + i] = 1'b1;
        end
        return m;
    endfunction

    function automatic clkctl_t clk_policy(input pmode_e mode,
                                           input logic sleep_dbg,
                                           input logic stop_dbg);
        clkctl_t c;
        case (mode)
            PM_SLEEP: begin
                c.fclk_en = 1'b1;
                c.hclk_en = sleep_dbg;
                c.sel_rc  = 1'b0;
            end
            PM_STOP: begin
                c.fclk_en = stop_dbg;
                c.hclk_en = stop_dbg;
                c.sel_rc  = stop_dbg;
            end
            default: begin
                c.fclk_en = 1'b1;
                c.hclk_en = 1'b1;
                c.sel_rc  = 1'b0;
            end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/dbgclk_regs.sv
module dbgclk_regs
    import dbgclk_pkg::*;
#(
    parameter int NUM_TIMERS = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [REG_W-1:0]        wr_data,
    output logic [REG_W-1:0]        rd_data,
    output logic                    sleep_dbg,
    output logic                    stop_dbg,
    output logic [NUM_TIMERS+1:0]   frz_sel
);
    localparam logic [REG_W-1:0] MASK = ctrl_mask(NUM_TIMERS);

    logic [REG_W-1:0] ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q <= wr_data & MASK;
        end
    end

    assign rd_data   = ctrl_q;
    assign sleep_dbg = ctrl_q[BIT_SLEEP_DBG];
    assign stop_dbg  = ctrl_q[BIT_STOP_DBG];
    assign frz_sel   = {ctrl_q[BIT_CAN_HOLD], ctrl_q[BIT_WDOG_FRZ],
                        ctrl_q[TIM_LSB +: NUM_TIMERS]};

    assert_write_back_R2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> rd_data == ($past(wr_data) & MASK));

endmodule

// File: rtl/dbgclk_pwr_fsm.sv
module dbgclk_pwr_fsm
    import dbgclk_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wait_exec,
    input  logic   deep_req,
    input  logic   wakeup,
    output pmode_e mode
);
    pmode_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        case (state_q)
            PM_RUN: begin
                if (wait_exec && !wakeup) begin
                    state_d = deep_req ? PM_STOP : PM_SLEEP;
                end
            end
            default: begin
                if (wakeup) begin
                    state_d = PM_RUN;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PM_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    assign mode = state_q;

    assert_entry_needs_wait_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == PM_RUN && !wait_exec) |=> state_q == PM_RUN);

    assert_wake_to_run_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q != PM_RUN && wakeup) |=> state_q == PM_RUN);

    assert_wait_wake_clash_R11: assert property (@(posedge clk) disable iff (rst)
        (state_q == PM_RUN && wait_exec && wakeup) |=> state_q == PM_RUN);

endmodule

// File: rtl/dbgclk_freeze.sv
module dbgclk_freeze #(
    parameter int NUM_CH = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              core_halted,
    input  logic [NUM_CH-1:0] frz_sel,
    output logic [NUM_CH-1:0] frz_out
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic frz_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                frz_q <= 1'b0;
            end else begin
                frz_q <= core_halted & frz_sel[g];
            end
        end
        assign frz_out[g] = frz_q;
    end

    assert_freeze_needs_halt_R9: assert property (@(posedge clk) disable iff (rst)
        (|frz_out) |-> $past(core_halted));

    assert_release_after_halt_R10: assert property (@(posedge clk) disable iff (rst)
        !core_halted |=> frz_out == '0);

endmodule

// File: rtl/dbgclk_ctrl.sv
module dbgclk_ctrl
    import dbgclk_pkg::*;
#(
    parameter int NUM_TIMERS = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [31:0]           wr_data,
    output logic [31:0]           rd_data,
    input  logic                  core_halted,
    input  logic                  wait_exec,
    input  logic                  deep_req,
    input  logic                  wakeup,
    output logic                  fclk_en,
    output logic                  hclk_en,
    output logic                  clk_sel_rc,
    output logic [NUM_TIMERS-1:0] tim_freeze,
    output logic                  wdog_freeze,
    output logic                  can_rx_hold
);
    localparam int NUM_CH = NUM_TIMERS + 2;

    logic              sleep_dbg, stop_dbg;
    logic [NUM_CH-1:0] frz_sel, frz_out;
    pmode_e            mode;
    clkctl_t           cc;

    dbgclk_regs #(.NUM_TIMERS(NUM_TIMERS)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .sleep_dbg (sleep_dbg),
        .stop_dbg  (stop_dbg),
        .frz_sel   (frz_sel)
    );

    dbgclk_pwr_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .wait_exec (wait_exec),
        .deep_req  (deep_req),
        .wakeup    (wakeup),
        .mode      (mode)
    );

    dbgclk_freeze #(.NUM_CH(NUM_CH)) u_frz (
        .clk         (clk),
        .rst         (rst),
        .core_halted (core_halted),
        .frz_sel     (frz_sel),
        .frz_out     (frz_out)
    );

    assign cc          = clk_policy(mode, sleep_dbg, stop_dbg);
    assign fclk_en     = cc.fclk_en;
    assign hclk_en     = cc.hclk_en;
    assign clk_sel_rc  = cc.sel_rc;
    assign tim_freeze  = frz_out[NUM_TIMERS-1:0];
    assign wdog_freeze = frz_out[NUM_TIMERS];
    assign can_rx_hold = frz_out[NUM_TIMERS+1];

    assert_sleep_gates_bus_R4: assert property (@(posedge clk) disable iff (rst)
        (mode == PM_SLEEP && !rd_data[BIT_SLEEP_DBG]) |-> (fclk_en && !hclk_en && !clk_sel_rc));

    assert_stop_gates_all_R6: assert property (@(posedge clk) disable iff (rst)
        (mode == PM_STOP && !rd_data[BIT_STOP_DBG]) |-> (!fclk_en && !hclk_en));

    assert_rc_only_in_dbg_stop_R7: assert property (@(posedge clk) disable iff (rst)
        clk_sel_rc |-> (fclk_en && hclk_en && mode == PM_STOP));

endmodule

// File: tb/tb_dbgclk_ctrl.sv
module tb_dbgclk_ctrl;
    localparam int NT = 4;
    localparam logic [31:0] MASK = 32'h0000_0F0F;

    logic          clk = 1'b0;
    logic          rst;
    logic          wr_en;
    logic [31:0]   wr_data;
    logic [31:0]   rd_data;
    logic          core_halted, wait_exec, deep_req, wakeup;
    logic          fclk_en, hclk_en, clk_sel_rc;
    logic [NT-1:0] tim_freeze;
    logic          wdog_freeze, can_rx_hold;

    int errors = 0;
    int checks = 0;

    logic [31:0]   m_ctrl;
    int            m_state;
    logic [NT-1:0] m_tim;
    logic          m_wd, m_can;

    always #10 clk = ~clk;

    dbgclk_ctrl #(.NUM_TIMERS(NT)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .core_halted(core_halted), .wait_exec(wait_exec), .deep_req(deep_req),
        .wakeup(wakeup), .fclk_en(fclk_en), .hclk_en(hclk_en), .clk_sel_rc(clk_sel_rc),
        .tim_freeze(tim_freeze), .wdog_freeze(wdog_freeze), .can_rx_hold(can_rx_hold)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic ef, eh, es;
        string tag;
        ef = 1'b1; eh = 1'b1; es = 1'b0; tag = "R8";
        if (m_state == 1) begin
            eh = m_ctrl[0];
            tag = m_ctrl[0] ? "R5" : "R4";
        end else if (m_state == 2) begin
            ef = m_ctrl[1]; eh = m_ctrl[1]; es = m_ctrl[1];
            tag = m_ctrl[1] ? "R7" : "R6";
        end
        check("R2 rd_data", rd_data, m_ctrl);
        check({tag, " fclk_en"}, {31'd0, fclk_en}, {31'd0, ef});
        check({tag, " hclk_en"}, {31'd0, hclk_en}, {31'd0, eh});
        check({tag, " clk_sel_rc"}, {31'd0, clk_sel_rc}, {31'd0, es});
        check("R9 tim_freeze", {28'd0, tim_freeze}, {28'd0, m_tim});
        check("R9 wdog_freeze", {31'd0, wdog_freeze}, {31'd0, m_wd});
        check("R10 can_rx_hold", {31'd0, can_rx_hold}, {31'd0, m_can});
    endtask

    task automatic step(input logic w, input logic [31:0] d, input logic h,
                        input logic we, input logic dr, input logic wk);
        logic [31:0] old;
        wr_en = w; wr_data = d; core_halted = h;
        wait_exec = we; deep_req = dr; wakeup = wk;
        @(posedge clk);
        old   = m_ctrl;
        m_tim = h ? old[8 +: NT] : '0;
        m_wd  = h & old[2];
        m_can = h & old[3];
        if (w) m_ctrl = d & MASK;
        if (m_state == 0) begin
            if (we && !wk) m_state = dr ? 2 : 1;
        end else if (wk) begin
            m_state = 0;
        end
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle(input logic h, input int n);
        for (int i = 0; i < n; i++) step(1'b0, 32'd0, h, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        #(20 * 5000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 0; wr_data = 0; core_halted = 1'b1;
        wait_exec = 0; deep_req = 0; wakeup = 0;
        m_ctrl = 0; m_state = 0; m_tim = 0; m_wd = 0; m_can = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state, even with halt asserted
        check("R1 rd_data", rd_data, 32'd0);
        check("R1 fclk_en", {31'd0, fclk_en}, 32'd1);
        check("R1 hclk_en", {31'd0, hclk_en}, 32'd1);
        check("R1 clk_sel_rc", {31'd0, clk_sel_rc}, 32'd0);
        check("R1 freezes", {26'd0, can_rx_hold, wdog_freeze, tim_freeze}, 32'd0);
        core_halted = 1'b0;
        idle(1'b0, 1);

        // R2: masking of unused bits
        step(1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R2 all-ones mask", rd_data, 32'h0000_0F0F);
        step(1'b1, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0);

        // R3: deep_req without wait keeps run mode
        step(1'b0, 0, 1'b0, 1'b0, 1'b1, 1'b0);
        step(1'b0, 0, 1'b0, 1'b0, 1'b1, 1'b0);
        check("R3 no entry without wait", {31'd0, hclk_en}, 32'd1);

        // R4 then R8
        step(1'b0, 0, 1'b0, 1'b1, 1'b0, 1'b0);
        idle(1'b0, 2);
        check("R4 bus gated in sleep", {31'd0, hclk_en}, 32'd0);
        step(1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b1);
        check("R8 back to run", {31'd0, hclk_en}, 32'd1);

        // R5: sleep with debug bit, set while sleeping
        step(1'b0, 0, 1'b0, 1'b1, 1'b0, 1'b0);
        step(1'b1, 32'h0000_0001, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R5 bus kept in debug sleep", {31'd0, hclk_en}, 32'd1);
        step(1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b1);

        // R6: plain stop
        step(1'b0, 0, 1'b0, 1'b1, 1'b1, 1'b0);
        idle(1'b0, 2);
        check("R6 all gated in stop", {30'd0, fclk_en, hclk_en}, 32'd0);
        step(1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b1);

        // R7: debug stop
        step(1'b1, 32'h0000_0002, 1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b0, 0, 1'b0, 1'b1, 1'b1, 1'b0);
        check("R7 rc select in debug stop", {31'd0, clk_sel_rc}, 32'd1);
        step(1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b1);
        check("R8 select back to system", {31'd0, clk_sel_rc}, 32'd0);

        // R11: wait and wakeup together
        step(1'b0, 0, 1'b0, 1'b1, 1'b1, 1'b1);
        check("R11 stays in run", {31'd0, fclk_en & ~clk_sel_rc}, 32'd1);
        idle(1'b0, 1);

        // R9 / R10: freeze patterns
        step(1'b1, 32'h0000_050C, 1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b0, 0, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R9 timers 0,2 frozen", {28'd0, tim_freeze}, 32'h5);
        check("R10 can held", {31'd0, can_rx_hold}, 32'd1);
        idle(1'b1, 3);
        idle(1'b0, 1);
        check("R9 released after halt", {28'd0, tim_freeze}, 32'h0);
        step(1'b1, 32'h0000_0A00, 1'b0, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 6; k++) step(1'b0, 0, k[0], 1'b0, 1'b0, 1'b0);
        step(1'b1, 32'h0000_0F04, 1'b1, 1'b0, 1'b0, 1'b0);
        idle(1'b1, 2);
        check("R9 watchdog frozen", {31'd0, wdog_freeze}, 32'd1);
        check("R10 can not held with bit clear", {31'd0, can_rx_hold}, 32'd0);
        // halt while in stop with debug
        step(1'b1, 32'h0000_010A, 1'b1, 1'b1, 1'b1, 1'b0);
        idle(1'b1, 2);
        step(1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b1);
        idle(1'b0, 2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule